// File: doc/BRIEF.md
# UART Character Framer with Parity and Wake-up Bit

This block frames and deframes asynchronous serial characters for one channel. On the transmit side it turns a parallel character into a serial frame: a low start bit, 5 to 8 data bits sent least significant bit first, an optional extra bit, and one or two high stop bits. On the receive side it finds the start bit, collects the same fields, and hands back the character with its error flags. The extra bit can be a computed parity bit (odd or even), a bit of fixed polarity, or an address/data marker used on multidrop lines where one master wakes selected slaves.

The frame format is held in two 8-bit configuration registers. A CPU reaches both through one data port, and an internal pointer steers each access. The pointer selects the first register after reset or after a pointer-select strobe. Any access to the first register moves the pointer to the second, where it stays. Bit timing comes from `baudTick`, a one-clock enable at the bit rate. Both directions advance only on that enable. The receive line is taken as already synchronous to `clk`, and there is no oversampling.

Top module: `uart_char_framer`

## Requirements
- R1: After reset `txd` is high, `txBusy` and `rxValid` are low, `rxData` is zero, both configuration registers are zero, and the pointer selects the first register.
- R2: `cfgRdData` shows the register the pointer selects, in the same cycle. A write stores `cfgWrData` there. Any read or write strobe moves the pointer from the first register to the second, and an access at the second leaves it there. `ptrSel` returns the pointer to the first register.
- R3: The first register holds the format. Bits [1:0] set the length: codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. Bit 2 is the type bit. Bits [4:3] set the extra-bit mode: 00 computed parity, 01 fixed bit, 10 none, 11 wake-up marker. Bit 0 of the second register selects two stop bits when 1. All 8 bits of each register read back as written.
- R4: When idle, a `txStart` pulse loads `txData`, and `txBusy` rises on the next cycle. Each later `baudTick` puts the next frame bit on `txd` one cycle after the tick. The order is start (0), data LSB first, the extra bit if any, then the stop bits (1). `txBusy` falls one cycle after the first tick that follows the last stop bit. `txd` is high whenever the transmitter is idle. A `txStart` pulse while busy is ignored.
- R5: The transmitted extra bit depends on the mode. With computed parity it is the XOR of the data bits when the type bit is 0 (even) and its inverse when the type bit is 1 (odd). With a fixed bit or a wake-up marker it equals the type bit. With no extra bit, none is sent. `txData` bits above the length are not sent.
- R6: While the receiver is idle, a `baudTick` with `rxd` low starts a frame. The following ticks sample the data bits, then the extra bit if there is one, then one stop bit. `rxValid` is high for exactly one cycle after the tick that samples the stop bit. `rxData` then holds the data bits with the unused upper bits at zero.
- R7: `rxParityErr` is set when the received extra bit differs from the computed parity (computed-parity mode) or from the type bit (fixed-bit mode). It is always 0 with no extra bit and in wake-up mode.
- R8: In wake-up mode `rxAddrFlag` carries the received extra bit. In every other mode it is 0.
- R9: `rxFrameErr` is set when the sampled stop bit is low. `rxBreak` is set when the data bits, the extra bit if any, and the stop bit are all low. Every break is also a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe to the register the pointer selects |
| cfgRdEn | input | 1 | Read strobe (advances the pointer) |
| ptrSel | input | 1 | Returns the pointer to the first register |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Contents of the register the pointer selects |
| baudTick | input | 1 | One-cycle enable at the bit rate |
| txStart | input | 1 | Start a transmit frame when idle |
| txData | input | 8 | Character to transmit |
| txBusy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, synchronous to clk |
| rxValid | output | 1 | One-cycle pulse: a received character is ready |
| rxData | output | 8 | Received character, zero-extended |
| rxParityErr | output | 1 | Received parity or fixed-bit mismatch |
| rxAddrFlag | output | 1 | Received wake-up address/data bit |
| rxFrameErr | output | 1 | Received stop bit was low |
| rxBreak | output | 1 | All received data, extra and stop bits were low |

## Verification
The bench uses the package defaults: an 8-bit data path and a 12-bit frame register. These are enough to reach every length code, all four extra-bit modes and both stop-bit settings. In each configuration the transmit line and busy flag are compared every clock against a queue-based model. A second transmit start is issued in the middle of a frame to show it is ignored. Receive frames are built to hit correct and wrong parity, both fixed polarities, a low stop bit, and a full break in both the no-extra-bit and wake-up modes.

// File: rtl/ufr_pkg.sv
package ufr_pkg;
  localparam int DATA_W  = 8;
  localparam int REG_W   = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_CALC  = 2'b00,
    PAR_FIXED = 2'b01,
    PAR_NONE  = 2'b10,
    PAR_WAKE  = 2'b11
  } extraMode_e;

  typedef struct packed {
    logic [1:0] lenCode;
    extraMode_e extraMode;
    logic       typeBit;
    logic       twoStop;
  } modeCfg_t;

  typedef struct packed {
    logic             txLoad;
    logic             txShift;
    logic             rxSample;
    logic             rxFinish;
    logic [CNT_W-1:0] rxIdx;
  } ctrlStrobe_t;

  function automatic int dataBits(input logic [1:0] code);
    return 5 + int'(code);
  endfunction
endpackage

// File: rtl/ufr_control.sv
module ufr_control
  import ufr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgRdEn,
  input  logic             ptrSel,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  input  logic             baudTick,
  input  logic             txStart,
  input  logic             rxd,
  output logic             txBusy,
  output modeCfg_t         cfg,
  output ctrlStrobe_t      strb
);
  logic             ptrAtB;
  logic [REG_W-1:0] modeA, modeB;
  logic [CNT_W-1:0] txCnt, rxIdx, nData, frameLen, stopIdx;
  logic             rxActive, hasExtra, loadNow, startNow, cfgAccess;

  assign cfgAccess = cfgWrEn | cfgRdEn;
  assign cfgRdData = ptrAtB ? modeB : modeA;

  assign cfg.lenCode   = modeA[1:0];
  assign cfg.typeBit   = modeA[2];
  assign cfg.extraMode = extraMode_e'(modeA[4:3]);
  assign cfg.twoStop   = modeB[0];

  assign hasExtra = (cfg.extraMode != PAR_NONE);
  assign nData    = CNT_W'(dataBits(cfg.lenCode));
  assign frameLen = nData + CNT_W'(2) + CNT_W'(hasExtra) + CNT_W'(cfg.twoStop);
  assign stopIdx  = nData + CNT_W'(hasExtra);

  // configuration registers and access pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrAtB <= 1'b0;
      modeA  <= '0;
      modeB  <= '0;
    end else begin
      if (cfgWrEn) begin
        if (ptrAtB) modeB <= cfgWrData;
        else        modeA <= cfgWrData;
      end
      if (ptrSel)         ptrAtB <= 1'b0;
      else if (cfgAccess) ptrAtB <= 1'b1;
    end
  end

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAccess && !ptrSel && !ptrAtB) |=> ptrAtB);
  // R2
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrSel |=> !ptrAtB);

  // transmit sequencing
  assign loadNow      = txStart && !txBusy;
  assign strb.txLoad  = loadNow;
  assign strb.txShift = txBusy && baudTick && (txCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (loadNow) begin
      txBusy <= 1'b1;
      txCnt  <= frameLen;
    end else if (txBusy && baudTick) begin
      if (txCnt != '0) txCnt  <= txCnt - CNT_W'(1);
      else             txBusy <= 1'b0;
    end
  end

  // R4
  tx_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txStart && !baudTick) |=> $stable(txCnt));

  // receive sequencing
  assign startNow      = !rxActive && baudTick && !rxd;
  assign strb.rxSample = rxActive && baudTick;
  assign strb.rxIdx    = rxIdx;
  assign strb.rxFinish = strb.rxSample && (rxIdx == stopIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxIdx    <= '0;
    end else if (startNow) begin
      rxActive <= 1'b1;
      rxIdx    <= '0;
    end else if (strb.rxSample) begin
      if (strb.rxFinish) rxActive <= 1'b0;
      else               rxIdx    <= rxIdx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ufr_datapath.sv
module ufr_datapath
  import ufr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  modeCfg_t          cfg,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  output logic              txd,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr,
  output logic              rxAddrFlag,
  output logic              rxFrameErr,
  output logic              rxBreak
);
  logic [DATA_W-1:0]  dataMask, txMasked, rxDataNext;
  logic [FRAME_W-1:0] txFrame, txShiftReg;
  logic [DATA_W:0]    rxBits;
  logic               hasExtra, txExtraBit, rxExtra, rxEven;
  int                 nDataInt;

  assign nDataInt = dataBits(cfg.lenCode);
  assign hasExtra = (cfg.extraMode != PAR_NONE);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) dataMask[i] = (i < nDataInt);
  end

  assign txMasked   = txData & dataMask;
  assign txExtraBit = (cfg.extraMode == PAR_CALC) ? ((^txMasked) ^ cfg.typeBit) : cfg.typeBit;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nDataInt) txFrame[i+1] = txData[i];
    for (int i = 0; i <= DATA_W; i++)
      if (hasExtra && i == nDataInt) txFrame[i+1] = txExtraBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '1;
      txd        <= 1'b1;
    end else if (strb.txLoad) begin
      txShiftReg <= txFrame;
    end else if (strb.txShift) begin
      txd        <= txShiftReg[0];
      txShiftReg <= {1'b1, txShiftReg[FRAME_W-1:1]};
    end
  end

  // receive field capture and decode
  assign rxDataNext = rxBits[DATA_W-1:0] & dataMask;
  assign rxEven     = ^rxDataNext;
  always_comb begin
    rxExtra = 1'b0;
    for (int i = 0; i <= DATA_W; i++)
      if (i == nDataInt) rxExtra = rxBits[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBits      <= '0;
      rxValid     <= 1'b0;
      rxData      <= '0;
      rxParityErr <= 1'b0;
      rxAddrFlag  <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxBreak     <= 1'b0;
    end else begin
      rxValid <= strb.rxFinish;
      if (strb.rxSample && !strb.rxFinish) begin
        for (int i = 0; i <= DATA_W; i++)
          if (int'(strb.rxIdx) == i) rxBits[i] <= rxd;
      end
      if (strb.rxFinish) begin
        rxData      <= rxDataNext;
        rxFrameErr  <= !rxd;
        rxBreak     <= !rxd && (rxDataNext == '0) && !(hasExtra && rxExtra);
        rxAddrFlag  <= (cfg.extraMode == PAR_WAKE) && rxExtra;
        case (cfg.extraMode)
          PAR_CALC:  rxParityErr <= rxExtra != (rxEven ^ cfg.typeBit);
          PAR_FIXED: rxParityErr <= rxExtra != cfg.typeBit;
          default:   rxParityErr <= 1'b0;
        endcase
      end
    end
  end

  // R6
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R9
  break_is_frame_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxBreak |-> rxFrameErr);
  // R8
  addr_excludes_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !(rxAddrFlag && rxParityErr));
endmodule

// File: rtl/uart_char_framer.sv
module uart_char_framer
  import ufr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic              ptrSel,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  cfgRdData,
  input  logic              baudTick,
  input  logic              txStart,
  input  logic [DATA_W-1:0] txData,
  output logic              txBusy,
  output logic              txd,
  input  logic              rxd,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr,
  output logic              rxAddrFlag,
  output logic              rxFrameErr,
  output logic              rxBreak
);
  modeCfg_t    cfg;
  ctrlStrobe_t strb;

  ufr_control i_control (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .ptrSel(ptrSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .baudTick(baudTick),
    .txStart(txStart), .rxd(rxd), .txBusy(txBusy), .cfg(cfg), .strb(strb)
  );

  ufr_datapath i_datapath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .txData(txData), .rxd(rxd),
    .txd(txd), .rxValid(rxValid), .rxData(rxData), .rxParityErr(rxParityErr),
    .rxAddrFlag(rxAddrFlag), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );

  // R4
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd);
endmodule

// File: tb/test_uart_char_framer.sv
module test_uart_char_framer;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 0, cfgRdEn = 0, ptrSel = 0, baudTick = 0, txStart = 0, rxd = 1;
  logic [7:0] cfgWrData = 0, txData = 0;
  logic [7:0] cfgRdData, rxData;
  logic txBusy, txd, rxValid, rxParityErr, rxAddrFlag, rxFrameErr, rxBreak;

  int checks = 0, fails = 0;
  string curReq = "R4";
  logic [1:0] bLen = 0, bPm = 0;
  logic bPt = 0, bTwo = 0;
  bit mBusy = 0, mTxd = 1;
  bit txQ[$];

  always #2 clk = ~clk;

  uart_char_framer i_uart_char_framer (.*);

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int nBits();
    return 5 + int'(bLen);
  endfunction

  function automatic bit evenOf(input logic [7:0] d);
    bit p = 0;
    for (int i = 0; i < nBits(); i++) p ^= d[i];
    return p;
  endfunction

  // behavioural transmit model
  always @(posedge clk) begin
    if (rstN) begin
      if (txStart && !mBusy) begin
        mBusy = 1;
        txQ.push_back(0);
        for (int i = 0; i < nBits(); i++) txQ.push_back(txData[i]);
        if (bPm == 2'b00) txQ.push_back(evenOf(txData) ^ bPt);
        else if (bPm != 2'b10) txQ.push_back(bPt);
        txQ.push_back(1);
        if (bTwo) txQ.push_back(1);
      end else if (baudTick && mBusy) begin
        if (txQ.size() > 0) mTxd = txQ.pop_front();
        else mBusy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "txd", int'(txd), int'(mTxd));
      check("R4", "txBusy", int'(txBusy), int'(mBusy));
    end
  end

  task automatic tick(input logic b);
    @(negedge clk); rxd = b; baudTick = 1;
    @(negedge clk); baudTick = 0; rxd = 1;
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic cfgRead(output logic [7:0] v);
    @(negedge clk); v = cfgRdData; cfgRdEn = 1;
    @(negedge clk); cfgRdEn = 0;
  endtask

  task automatic setMode(input logic [1:0] len, input logic [1:0] pm, input logic pt, input logic two);
    @(negedge clk); ptrSel = 1;
    @(negedge clk); ptrSel = 0;
    cfgWrite({3'b000, pm, pt, len});
    cfgWrite({7'b0, two});
    bLen = len; bPm = pm; bPt = pt; bTwo = two;
  endtask

  task automatic sendTx(input logic [7:0] d, input string req, input bit poke);
    curReq = req;
    @(negedge clk); txStart = 1; txData = d;
    @(negedge clk); txStart = 0;
    for (int i = 0; i < 15; i++) begin
      if (poke && i == 3) begin
        @(negedge clk); txStart = 1; txData = ~d;
        @(negedge clk); txStart = 0;
      end
      tick(1);
    end
    check("R4", "busy after frame", int'(txBusy), 0);
    curReq = "R4";
  endtask

  task automatic sendRx(input logic [7:0] d, input logic extra, input logic stop);
    logic [7:0] eData;
    bit ePe, eBrk;
    bit bits[$];
    eData = d & ((8'd1 << nBits()) - 8'd1);
    bits.push_back(0);
    for (int i = 0; i < nBits(); i++) bits.push_back(d[i]);
    if (bPm != 2'b10) bits.push_back(extra);
    bits.push_back(stop);
    foreach (bits[i]) begin
      if (i > 0) check("R6", "rxValid early", int'(rxValid), 0);
      tick(bits[i]);
    end
    ePe = (bPm == 2'b00) ? (extra != (evenOf(d) ^ bPt)) :
          (bPm == 2'b01) ? (extra != bPt) : 0;
    eBrk = !stop && eData == 0 && !(bPm != 2'b10 && extra);
    check("R6", "rxValid", int'(rxValid), 1);
    check("R6", "rxData", int'(rxData), int'(eData));
    check("R7", "rxParityErr", int'(rxParityErr), int'(ePe));
    check("R8", "rxAddrFlag", int'(rxAddrFlag), int'(bPm == 2'b11 && extra));
    check("R9", "rxFrameErr", int'(rxFrameErr), int'(!stop));
    check("R9", "rxBreak", int'(rxBreak), int'(eBrk));
    @(negedge clk);
    check("R6", "rxValid one cycle", int'(rxValid), 0);
    tick(1); tick(1);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "txd", int'(txd), 1);
    check("R1", "txBusy", int'(txBusy), 0);
    check("R1", "rxValid", int'(rxValid), 0);
    check("R1", "rxData", int'(rxData), 0);
    check("R1", "cfgRdData", int'(cfgRdData), 0);
    rstN = 1;
    // R2 pointer behaviour, R3 full-width readback
    cfgWrite(8'hE9);
    cfgRead(v); check("R2", "second reg after first write", int'(v), 0);
    cfgWrite(8'h5B);
    cfgWrite(8'hA6);
    cfgRead(v); check("R2", "second reg stays", int'(v), 8'hA6);
    @(negedge clk); ptrSel = 1;
    @(negedge clk); ptrSel = 0;
    cfgRead(v); check("R3", "first reg readback", int'(v), 8'hE9);
    cfgRead(v); check("R2", "read advanced pointer", int'(v), 8'hA6);

    // transmit, R5 variants
    setMode(2'b11, 2'b00, 0, 0); sendTx(8'hA5, "R5", 0);
    setMode(2'b00, 2'b00, 1, 0); sendTx(8'hFF, "R5", 0);
    setMode(2'b10, 2'b01, 1, 1); sendTx(8'h13, "R5", 1);
    setMode(2'b01, 2'b10, 1, 0); sendTx(8'h2C, "R5", 0);
    setMode(2'b11, 2'b11, 0, 1); sendTx(8'h81, "R5", 0);
    setMode(2'b11, 2'b11, 1, 0); sendTx(8'h7E, "R4", 1);

    // receive
    setMode(2'b11, 2'b00, 0, 0);
    sendRx(8'h3C, 0, 1);
    sendRx(8'h3C, 1, 1);
    setMode(2'b00, 2'b00, 1, 0);
    sendRx(8'hF3, 0, 1);
    sendRx(8'hF3, 1, 1);
    setMode(2'b10, 2'b01, 1, 1);
    sendRx(8'h55, 0, 1);
    sendRx(8'h55, 1, 1);
    setMode(2'b10, 2'b10, 0, 0);
    sendRx(8'h41, 0, 0);
    setMode(2'b11, 2'b10, 0, 0);
    sendRx(8'h00, 0, 0);
    setMode(2'b11, 2'b11, 0, 0);
    sendRx(8'hC4, 1, 1);
    sendRx(8'hC4, 0, 1);
    sendRx(8'h00, 0, 0);
    sendRx(8'h00, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule